// File: doc/BRIEF.md
# Key-Restarted Watchdog Timer

This block is a watchdog timer that a processor reaches over a simple register bus. The bus has a 32-bit address, 32-bit write data, 32-bit read data, a write strobe and a read strobe. A down-counter runs from a timeout chosen among sixteen power-of-two lengths. Software keeps the system alive by writing a fixed key to a restart register before the count runs out. When the count expires, the block does one of two things, chosen by a response-mode bit. It either pulses a system-reset output at once, or it first raises an interrupt and pulses the reset only if a second expiry arrives while the interrupt is still pending.

The enable bit can be set by software but never cleared by it. Only the block's own reset input returns it to zero. A separate initial-period field sets the length of the first count after enabling; every later reload uses the regular period field. Writes take effect at the clock edge on which the write strobe is sampled. Read data is registered: it appears one cycle after the read strobe and reads as zero in every cycle without a read. The bus carries no data stream, so it has no valid/ready handshake and never stalls.

Top module: `wdog_timer`

## Requirements
- R1: Registers are decoded on full 32-bit addresses: control at 0x00, timeout select at 0x04, live count at 0x08 (read-only), restart at 0x0C. Read data is valid in the cycle after the read strobe. Unmapped offsets read as 0, and bus_rdata is 0 in any cycle that follows a cycle with no read strobe.
- R2: Control bit 0 is the enable and bit 1 is the response mode. Reading the control register returns {mode, enable} in bits [1:0] and zero above them.
- R3: Once the enable bit is 1, a control write with bit 0 clear leaves it at 1. Only rst_n clears it. The mode bit follows every control write.
- R4: Timeout-select bits [3:0] choose the reload period and bits [7:4] choose the initial period. Index i stands for 2^(BASE_EXP+i) clock cycles. The register reads back both fields in those positions.
- R5: While disabled, the counter holds the initial-period length (changes show one cycle after the write) and does not decrement. Once enabled, it decreases by one every cycle from that value and never reads 0.
- R6: Expiry is the cycle in which the enabled counter reads 1 and no restart is written. On expiry the counter reloads from the reload period. With mode 0, expiry drives sys_rst high for exactly RST_PULSE cycles, starting the next cycle, and irq stays low.
- R7: With mode 1, an expiry while irq is low sets irq. An expiry while irq is high clears irq and starts the RST_PULSE-cycle sys_rst pulse.
- R8: Writing exactly 32'h0000_0076 to 0x0C while enabled reloads the counter from the reload period and clears irq. Any other write data is ignored, and restart writes while disabled are ignored.
- R9: A valid restart written in a cycle in which the counter reads 1 wins over expiry: no interrupt and no reset pulse result.
- R10: After reset, control and timeout select read 0, the count reads 2^BASE_EXP, and irq and sys_rst are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | First-expiry interrupt (mode 1) |
| sys_rst | output | 1 | System-reset pulse |

## Verification
Register writes are visible at the edge that samples the strobe. A read's data is due one edge after the read strobe and reflects the state just before that edge. An expiry decided at edge E reloads the counter at E, shows irq after E, and holds sys_rst high from E for RST_PULSE edges. A restart written at edge k shows as the period minus one when read back two edges later. The bench drives and samples only on falling edges. It advances a behavioural model at every rising edge and compares irq, sys_rst and bus_rdata against that model after each edge. Directed checks aim at these exact cycles, including a restart placed in the cycle where the count reads 1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] OFF_CTRL  = 32'h0000_0000;
  localparam logic [31:0] OFF_SEL   = 32'h0000_0004;
  localparam logic [31:0] OFF_COUNT = 32'h0000_0008;
  localparam logic [31:0] OFF_KICK  = 32'h0000_000C;
  localparam logic [31:0] KICK_KEY  = 32'h0000_0076;

  localparam int NUM_PERIODS = 16;
  localparam int SEL_W       = 4;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [SEL_W-1:0] init_sel;
    logic [SEL_W-1:0] run_sel;
  } sel_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [31:0]      rdata_o,
  output ctrl_t            ctrl_o,
  output sel_t             sel_o,
  output logic             kick_o
);
  ctrl_t       ctrl_q;
  sel_t        sel_q;
  logic [31:0] cnt_ext;
  logic [31:0] rd_mux;

  generate
    if (CNT_W >= 32) begin : g_trunc
      assign cnt_ext = cnt_i[31:0];
    end else begin : g_pad
      assign cnt_ext = {{(32-CNT_W){1'b0}}, cnt_i};
    end
  endgenerate

  // Enable is sticky: only rst_n clears it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_CTRL) begin
        ctrl_q.en   <= ctrl_q.en | wdata_i[0];
        ctrl_q.mode <= wdata_i[1];
      end
      if (addr_i == OFF_SEL) begin
        sel_q <= sel_t'(wdata_i[2*SEL_W-1:0]);
      end
    end
  end

  // Key match only counts when the block is running.
  assign kick_o = wr_i && ctrl_q.en && (addr_i == OFF_KICK) && (wdata_i == KICK_KEY);

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_CTRL:  rd_mux = {30'd0, ctrl_q};
      OFF_SEL:   rd_mux = {24'd0, sel_q};
      OFF_COUNT: rd_mux = cnt_ext;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_i ? rd_mux : '0;
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ctrl_q.en); // R3
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == 32'd0)); // R1
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + NUM_PERIODS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             kick_i,
  input  sel_t             sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] per_tab [NUM_PERIODS];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] init_len;

  // One power-of-two length per select index.
  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_per
    assign per_tab[g] = ONE << (BASE_EXP + g);
  end

  assign run_len  = per_tab[sel_i.run_sel];
  assign init_len = per_tab[sel_i.init_sel];

  // A restart in the last cycle beats the expiry.
  assign expire_o = en_i && (cnt_q == ONE) && !kick_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= per_tab[0];
    else if (!en_i)             cnt_q <= init_len;
    else if (kick_i || expire_o) cnt_q <= run_len;
    else                        cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q != '0)); // R5
  AST_KICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && kick_i) |=> (cnt_q == $past(run_len))); // R8
endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic kick_i,
  input  logic mode_i,
  output logic irq_o,
  output logic sys_rst_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic          irq_q;
  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
      if (kick_i)        irq_q   <= 1'b0;
      if (expire_i) begin
        if (mode_i && !irq_q) begin
          irq_q <= 1'b1;
        end else begin
          irq_q   <= 1'b0;
          pulse_q <= PW'(RST_PULSE);
        end
      end
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pulse_q != '0);

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !irq_o); // R8
  AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !mode_i) |=> (sys_rst_o && !irq_o)); // R6
  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && mode_i && !irq_o) |=> irq_o); // R7
  AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && mode_i && irq_o) |=> (sys_rst_o && !irq_o)); // R7
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int RST_PULSE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sys_rst
);
  localparam int CNT_W = BASE_EXP + NUM_PERIODS;

  ctrl_t            ctrl;
  sel_t             sel;
  logic             kick;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .cnt_i   (cnt),
    .rdata_o (bus_rdata),
    .ctrl_o  (ctrl),
    .sel_o   (sel),
    .kick_o  (kick)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ctrl.en),
    .kick_i   (kick),
    .sel_i    (sel),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdt_response #(.RST_PULSE(RST_PULSE)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .kick_i    (kick),
    .mode_i    (ctrl.mode),
    .irq_o     (irq),
    .sys_rst_o (sys_rst)
  );

  AST_NO_RST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !sys_rst) |=> !sys_rst); // R5
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;
  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        sys_rst;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  wdog_timer #(.BASE_EXP(BASE), .RST_PULSE(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model.
  int     m_en = 0, m_mode = 0, m_run = 0, m_init = 0, m_irq = 0, m_pulse = 0;
  longint m_cnt = 4, m_rdata = 0;

  function automatic longint per(int s);
    return longint'(1) << (BASE + s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_run = 0; m_init = 0; m_irq = 0; m_pulse = 0;
      m_cnt = per(0); m_rdata = 0;
    end else begin
      bit kick, exp_now;
      longint n_cnt, n_rd;
      int n_irq, n_pulse;
      kick = bus_wr && bus_addr == 32'hC && bus_wdata == 32'h76 && m_en == 1;
      exp_now = m_en == 1 && m_cnt == 1 && !kick;
      n_rd = 0;
      if (bus_rd) begin
        if (bus_addr == 0) n_rd = m_mode * 2 + m_en;
        else if (bus_addr == 4) n_rd = m_init * 16 + m_run;
        else if (bus_addr == 8) n_rd = m_cnt;
      end
      if (m_en == 0) n_cnt = per(m_init);
      else if (kick || exp_now) n_cnt = per(m_run);
      else n_cnt = m_cnt - 1;
      n_pulse = (m_pulse > 0) ? m_pulse - 1 : 0;
      n_irq = kick ? 0 : m_irq;
      if (exp_now) begin
        if (m_mode == 1 && m_irq == 0) n_irq = 1;
        else begin n_irq = 0; n_pulse = PULSE; end
      end
      if (bus_wr && bus_addr == 0) begin
        if (bus_wdata[0]) m_en = 1;
        m_mode = int'(bus_wdata[1]);
      end
      if (bus_wr && bus_addr == 4) begin
        m_run = int'(bus_wdata[3:0]);
        m_init = int'(bus_wdata[7:4]);
      end
      m_cnt = n_cnt; m_rdata = n_rd; m_irq = n_irq; m_pulse = n_pulse;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R7", "irq vs model", irq, m_irq);
      chk("R6", "sys_rst vs model", sys_rst, (m_pulse > 0) ? 1 : 0);
      chk("R1", "rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output longint v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1-watchdog: actual=hung expected=finished");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint v;
    int n;
    repeat (2) @(negedge clk);
    started = 1;
    rst_n = 1'b1;

    // R10 reset values
    rd(32'h0, v);  chk("R10", "ctrl after reset", v, 0);
    rd(32'h4, v);  chk("R10", "select after reset", v, 0);
    rd(32'h8, v);  chk("R10", "count after reset", v, 4);
    chk("R10", "sys_rst after reset", sys_rst, 0);
    // R1 unmapped
    rd(32'h10, v); chk("R1", "unmapped 0x10", v, 0);
    rd(32'h1000_0008, v); chk("R1", "aliased high address", v, 0);

    // R4 / R5 disabled behaviour
    wr(32'h4, 32'h31);
    rd(32'h4, v);  chk("R4", "select readback", v, 32'h31);
    rd(32'h8, v);  chk("R5", "disabled count = init period", v, 32);
    repeat (5) @(negedge clk);
    rd(32'h8, v);  chk("R5", "no decrement while disabled", v, 32);
    wr(32'hC, 32'h76);
    rd(32'h8, v);  chk("R8", "restart ignored while disabled", v, 32);

    // R2 / R3 enable, mode 0
    wr(32'h0, 32'h1);
    rd(32'h0, v);  chk("R2", "ctrl enabled mode0", v, 1);
    wr(32'h0, 32'h0);
    rd(32'h0, v);  chk("R3", "enable cannot be cleared", v, 1);
    rd(32'h8, v);  chk("R5", "counting from init period", v, m_rdata);
    chk("R5", "count below init", (v < 32) ? 1 : 0, 1);

    // R8 wrong keys
    wr(32'hC, 32'h75);
    wr(32'hC, 32'h176);
    rd(32'h8, v);  chk("R8", "wrong key ignored (no reload to 8)", (v > 8) ? 1 : 0, 1);
    // R8 correct key
    wr(32'hC, 32'h76);
    rd(32'h8, v);  chk("R8", "reload from run period", v, 7);

    // R6 mode-0 expiry
    while (!sys_rst) @(negedge clk);
    n = 0;
    while (sys_rst) begin
      chk("R6", "irq low in mode 0", irq, 0);
      n++; @(negedge clk);
    end
    chk("R6", "reset pulse length", n, PULSE);

    // R9 restart in expiry cycle
    while (m_cnt != 1) @(negedge clk);
    bus_addr = 32'hC; bus_wdata = 32'h76; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk("R9", "no pulse after last-cycle restart", sys_rst, 0);
      @(negedge clk);
    end

    // R7 mode 1 from a fresh reset
    do_reset();
    wr(32'h4, 32'h00);
    wr(32'h0, 32'h3);
    rd(32'h0, v);  chk("R2", "ctrl enabled mode1", v, 3);
    while (!irq) @(negedge clk);
    chk("R7", "first expiry no reset", sys_rst, 0);
    wr(32'hC, 32'h76);
    chk("R8", "restart clears irq", irq, 0);
    while (!irq) @(negedge clk);
    n = 0;
    while (!sys_rst) begin n++; @(negedge clk); end
    chk("R7", "second expiry one period after irq", n, 4);
    chk("R7", "irq cleared with reset pulse", irq, 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule